// File: doc/BRIEF.md
# Stored-Program Byte Processor Core

This block is a compact multi-cycle processor. Programs and data live together in one byte-wide memory outside the block. Every instruction is a 16-bit word held in two neighbouring bytes. The top nibble of the word is the opcode. The three nibbles below it are operand fields whose meaning depends on the opcode. The core has sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. It loops through fetch, decode and execute until it meets a halt instruction.

Software places a program in memory, drives a start address and pulses `go` for one cycle. The core then runs on its own. When it executes a halt it raises `halted` and stops touching memory. Another `go` pulse restarts it at a new start address, and the register contents are kept. The memory port carries no handshake. The memory must present read data one cycle after the address, and it must accept a write in the cycle `mem_we` is high. Neither side can stall the other, so the port has no back-pressure. `go`, `start_addr` and `halted` are plain control and status pins.

Top module: `byte_cpu_core`

## Requirements
- R1: While reset is asserted and afterwards until the first `go`, `halted` is 0 and `mem_we` is 0, and the core writes nothing to memory.
- R2: Fetch reads two bytes. The high byte comes from address PC and the low byte from address PC+1, on consecutive cycles. The PC then advances by 2. An instruction takes 4 cycles, and a memory load takes 5. The cycle count is measured from the edge that samples `go` to the edge that sets `halted`.
- R3: Opcode 1 (fields R, XY) loads register R from memory address XY. Opcode 2 (fields R, XY) loads the constant byte XY into register R.
- R4: Opcode 3 (fields R, XY) writes register R to memory address XY with one single-cycle `mem_we` pulse. No other address is written.
- R5: Opcode 4 (fields 0, R, S, in the three low nibbles from high to low) copies register R into register S.
- R6: Opcode 5 (fields R, S, T) writes S + T modulo 256 into R. Carry is dropped and no flags are kept.
- R7: Opcodes 7, 8 and 9 (fields R, S, T) write S OR T, S AND T and S XOR T into R.
- R8: Opcode A (fields R, 0, X) rotates register R right by X bit positions. The bits leaving bit 0 re-enter at bit 7. A count of 0, or of 8, leaves R unchanged.
- R9: Opcode B (fields R, XY) jumps to XY when register R equals register 0. Otherwise execution continues with the next instruction.
- R10: Opcode C stops the core. `halted` goes to 1 and stays there. `mem_we` stays 0 and `mem_addr` holds steady until the next `go`.
- R11: Opcodes 0, 6, D, E and F change no register and no memory byte. They only advance the PC.
- R12: When the destination register is also a source of the same instruction, the operation uses the register's value from before that instruction.
- R13: A `go` pulse while halted clears `halted` at the sampling edge, loads `start_addr` into the PC and resumes fetching there. Register contents from the previous run are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | One-cycle start pulse, honoured when idle or halted |
| start_addr | input | 8 | First instruction address taken on `go` |
| halted | output | 1 | High after a halt instruction |
| mem_addr | output | 8 | Memory address for a read or a write |
| mem_wdata | output | 8 | Store data |
| mem_we | output | 1 | Write strobe for `mem_addr` |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |

## Verification
One instruction can read and write the same register in a single cycle. This happens when an operand register is also the destination of that instruction. The register file then returns the old value while the new value is clocked in at the same edge. The bench provokes this with an add of a register to itself, an exclusive-or of a register with itself and a rotate in place. It stores the results and compares them with values worked out from the pre-instruction contents. A stale or forwarded value would give a different byte.

// File: rtl/bcpu_pkg.sv
package bcpu_pkg;

  localparam int NIB_W    = 4;
  localparam int RD_PORTS = 4;

  typedef enum logic [3:0] {
    OP_NOP0 = 4'h0,
    OP_LDM  = 4'h1,
    OP_LDI  = 4'h2,
    OP_STM  = 4'h3,
    OP_MOV  = 4'h4,
    OP_ADD  = 4'h5,
    OP_FADD = 4'h6,
    OP_OR   = 4'h7,
    OP_AND  = 4'h8,
    OP_XOR  = 4'h9,
    OP_ROR  = 4'hA,
    OP_JEQ  = 4'hB,
    OP_HLT  = 4'hC
  } opcode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FHI,
    ST_FLO,
    ST_DEC,
    ST_EXE,
    ST_MRD,
    ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    FN_PASS,
    FN_ADD,
    FN_OR,
    FN_AND,
    FN_XOR,
    FN_ROR
  } alu_fn_e;

endpackage

// File: rtl/bcpu_regfile.sv
module bcpu_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 16,
  parameter int NRD    = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx  [NRD],
  output logic [DATA_W-1:0] rd_data [NRD],
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_idx] <= wr_data;
    end
  end

  // Combinational read ports: same-cycle reads see the pre-write value (R12)
  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_data[p] = regs[rd_idx[p]];
    end
  endgenerate

endmodule

// File: rtl/bcpu_alu.sv
module bcpu_alu import bcpu_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] y
);

  // Barrel rotator: stage k rotates right by 2**k when cnt[k] is set
  logic [DATA_W-1:0] rot [CNT_W+1];
  assign rot[0] = a;

  generate
    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
      localparam int SH = (1 << k) % DATA_W;
      if (SH == 0) begin : g_full
        assign rot[k+1] = rot[k];
      end else begin : g_part
        assign rot[k+1] = cnt[k] ? {rot[k][SH-1:0], rot[k][DATA_W-1:SH]} : rot[k];
      end
    end
  endgenerate

  always_comb begin
    unique case (fn)
      FN_ADD:  y = a + b;
      FN_OR:   y = a | b;
      FN_AND:  y = a & b;
      FN_XOR:  y = a ^ b;
      FN_ROR:  y = rot[CNT_W];
      default: y = a;
    endcase
  end

  // R8: zero-count rotate must return the operand untouched
  always_comb begin
    if (fn == FN_ROR && cnt == '0) begin
      p_rot_zero_keeps_r8: assert (y == a);
    end
  end

endmodule

// File: rtl/bcpu_ctrl.sv
module bcpu_ctrl import bcpu_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int IR_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] start_addr,
  output logic              halted,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rd_idx  [RD_PORTS],
  input  logic [DATA_W-1:0] rd_data [RD_PORTS],
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output alu_fn_e           alu_fn,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b,
  output logic [NIB_W-1:0]  alu_cnt,
  input  logic [DATA_W-1:0] alu_y
);

  state_e            state;
  logic [DATA_W-1:0] pc;
  logic [IR_W-1:0]   ir;

  opcode_e           op;
  logic [NIB_W-1:0]  f1, f2, f3;
  logic [DATA_W-1:0] xy;
  logic              regs_equal;

  assign op = opcode_e'(ir[IR_W-1 -: NIB_W]);
  assign f1 = ir[3*NIB_W-1 -: NIB_W];
  assign f2 = ir[2*NIB_W-1 -: NIB_W];
  assign f3 = ir[NIB_W-1:0];
  assign xy = ir[DATA_W-1:0];

  // Port 0: field 1, port 1: field 2, port 2: field 3, port 3: register 0
  assign rd_idx[0] = IDX_W'(f1);
  assign rd_idx[1] = IDX_W'(f2);
  assign rd_idx[2] = IDX_W'(f3);
  assign rd_idx[3] = '0;
  assign regs_equal = (rd_data[0] == rd_data[3]);

  always_comb begin
    mem_addr  = pc;
    mem_we    = 1'b0;
    mem_wdata = rd_data[0];
    wr_en     = 1'b0;
    wr_idx    = IDX_W'(f1);
    wr_data   = alu_y;
    alu_fn    = FN_PASS;
    alu_a     = rd_data[1];
    alu_b     = rd_data[2];
    alu_cnt   = f3;
    case (state)
      ST_FLO: mem_addr = pc + 1'b1;
      ST_EXE: begin
        case (op)
          OP_LDM: mem_addr = xy;
          OP_LDI: begin
            wr_en   = 1'b1;
            wr_data = xy;
          end
          OP_STM: begin
            mem_addr = xy;
            mem_we   = 1'b1;
          end
          OP_MOV: begin
            wr_en  = 1'b1;
            wr_idx = IDX_W'(f3);
          end
          OP_ADD: begin wr_en = 1'b1; alu_fn = FN_ADD; end
          OP_OR:  begin wr_en = 1'b1; alu_fn = FN_OR;  end
          OP_AND: begin wr_en = 1'b1; alu_fn = FN_AND; end
          OP_XOR: begin wr_en = 1'b1; alu_fn = FN_XOR; end
          OP_ROR: begin
            wr_en  = 1'b1;
            alu_fn = FN_ROR;
            alu_a  = rd_data[0];
          end
          default: ;
        endcase
      end
      ST_MRD: begin
        wr_en   = 1'b1;
        wr_data = mem_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pc     <= '0;
      ir     <= '0;
      halted <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_HALT: begin
          if (go) begin
            pc     <= start_addr;
            halted <= 1'b0;
            state  <= ST_FHI;
          end
        end
        ST_FHI: state <= ST_FLO;
        ST_FLO: begin
          ir[IR_W-1:DATA_W] <= mem_rdata;
          state <= ST_DEC;
        end
        ST_DEC: begin
          ir[DATA_W-1:0] <= mem_rdata;
          pc    <= pc + DATA_W'(2);
          state <= ST_EXE;
        end
        ST_EXE: begin
          case (op)
            OP_LDM: state <= ST_MRD;
            OP_JEQ: begin
              if (regs_equal) pc <= xy;
              state <= ST_FHI;
            end
            OP_HLT: begin
              halted <= 1'b1;
              state  <= ST_HALT;
            end
            default: state <= ST_FHI;
          endcase
        end
        ST_MRD:  state <= ST_FHI;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: low byte is requested right after the high byte
  p_fetch_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FHI) |=> (mem_addr == DATA_W'($past(mem_addr) + 1)));

  // R2: PC advances by two per fetched word
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEC) |=> (pc == DATA_W'($past(pc) + 2)));

  // R4: a store is a single-cycle strobe
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R10: no writes while stopped
  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  // R10: stopped core stays stopped with a steady address
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !go) |=> (halted && $stable(mem_addr)));

  // R13: restart clears halted and takes the start address
  p_go_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && go) |=> (!halted && pc == $past(start_addr)));

endmodule

// File: rtl/byte_cpu_core.sv
module byte_cpu_core import bcpu_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int NREG   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] start_addr,
  output logic              halted,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int IDX_W = $clog2(NREG);

  logic [IDX_W-1:0]  rd_idx  [RD_PORTS];
  logic [DATA_W-1:0] rd_data [RD_PORTS];
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  alu_fn_e           alu_fn;
  logic [DATA_W-1:0] alu_a, alu_b, alu_y;
  logic [NIB_W-1:0]  alu_cnt;

  bcpu_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NRD(RD_PORTS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data)
  );

  bcpu_alu #(.DATA_W(DATA_W), .CNT_W(NIB_W)) u_alu (
    .fn  (alu_fn),
    .a   (alu_a),
    .b   (alu_b),
    .cnt (alu_cnt),
    .y   (alu_y)
  );

  bcpu_ctrl #(.DATA_W(DATA_W), .NREG(NREG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .start_addr (start_addr),
    .halted     (halted),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_rdata  (mem_rdata),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .alu_fn     (alu_fn),
    .alu_a      (alu_a),
    .alu_b      (alu_b),
    .alu_cnt    (alu_cnt),
    .alu_y      (alu_y)
  );

endmodule

// File: tb/byte_cpu_core_tb_top.sv
`timescale 1ns/1ps
module byte_cpu_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0;
  logic [7:0] start_addr = 8'h00;
  logic       halted;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we;
  logic [7:0] mem [256];
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  byte_cpu_core dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .start_addr(start_addr),
    .halted(halted), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  // Synchronous memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    go = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] w);
    mem[a] <= w[15:8];
    mem[a + 8'd1] <= w[7:0];
  endtask

  // Pulse go, count edges from the go-sampling edge until halted
  task automatic run(input logic [7:0] sa, output int cyc, output logic h0);
    @(negedge clk);
    start_addr = sa;
    go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go = 1'b0;
    h0 = halted;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    if (cyc >= 2000) chk("run timeout", 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    int we_seen = 0;
    do_reset();
    chk("R1 halted after reset", halted, 1'b0);
    chk("R1 we after reset", mem_we, 1'b0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mem_we) we_seen++;
    end
    chk("R1 no writes while idle", we_seen, 0);
  endtask

  task automatic t_load_store();
    int c; logic h;
    do_reset(); clear_mem();
    mem[8'h80] <= 8'hC3;
    put(8'h40, 16'h215A); put(8'h42, 16'h1280); put(8'h44, 16'h3190);
    put(8'h46, 16'h3291); put(8'h48, 16'hC000);
    run(8'h40, c, h);
    chk("R3 immediate load", mem[8'h90], 8'h5A);
    chk("R3 memory load", mem[8'h91], 8'hC3);
    chk("R4 neighbour untouched", mem[8'h92], 8'h00);
    chk("R2 cycle count 4n+loads", c, 21);
  endtask

  task automatic t_alu();
    int c; logic h;
    do_reset(); clear_mem();
    put(8'h10, 16'h21F0); put(8'h12, 16'h223C); put(8'h14, 16'h5312);
    put(8'h16, 16'h7412); put(8'h18, 16'h8512); put(8'h1A, 16'h9612);
    put(8'h1C, 16'h4017); put(8'h1E, 16'h287F); put(8'h20, 16'h2901);
    put(8'h22, 16'h5A89); put(8'h24, 16'h33A0); put(8'h26, 16'h34A1);
    put(8'h28, 16'h35A2); put(8'h2A, 16'h36A3); put(8'h2C, 16'h37A4);
    put(8'h2E, 16'h3AA5); put(8'h30, 16'hC000);
    run(8'h10, c, h);
    chk("R6 add wraps", mem[8'hA0], 8'h2C);
    chk("R6 add 7F+01", mem[8'hA5], 8'h80);
    chk("R7 or", mem[8'hA1], 8'hFC);
    chk("R7 and", mem[8'hA2], 8'h30);
    chk("R7 xor", mem[8'hA3], 8'hCC);
    chk("R5 move", mem[8'hA4], 8'hF0);
  endtask

  task automatic t_rotate();
    int c; logic h;
    do_reset(); clear_mem();
    put(8'h00, 16'h2165); put(8'h02, 16'hA101); put(8'h04, 16'h2281);
    put(8'h06, 16'hA203); put(8'h08, 16'h235A); put(8'h0A, 16'hA300);
    put(8'h0C, 16'h2496); put(8'h0E, 16'hA408); put(8'h10, 16'h31C0);
    put(8'h12, 16'h32C1); put(8'h14, 16'h33C2); put(8'h16, 16'h34C3);
    put(8'h18, 16'hC000);
    run(8'h00, c, h);
    chk("R8 rotate by 1", mem[8'hC0], 8'hB2);
    chk("R8 rotate by 3", mem[8'hC1], 8'h30);
    chk("R8 rotate by 0", mem[8'hC2], 8'h5A);
    chk("R8 rotate by 8", mem[8'hC3], 8'h96);
  endtask

  task automatic t_jump();
    int c; logic h;
    do_reset(); clear_mem();
    put(8'h20, 16'h2007); put(8'h22, 16'h2107); put(8'h24, 16'h2208);
    put(8'h26, 16'hB230); put(8'h28, 16'h2511); put(8'h2A, 16'hB12E);
    put(8'h2C, 16'h2622); put(8'h2E, 16'h2733); put(8'h30, 16'h35D0);
    put(8'h32, 16'h36D1); put(8'h34, 16'h37D2); put(8'h36, 16'hC000);
    run(8'h20, c, h);
    chk("R9 not taken falls through", mem[8'hD0], 8'h11);
    chk("R9 taken skips", mem[8'hD1], 8'h00);
    chk("R9 target executed", mem[8'hD2], 8'h33);
    chk("R9 cycle count", c, 44);
  endtask

  task automatic t_nop();
    int c; logic h;
    do_reset(); clear_mem();
    put(8'h60, 16'h2144); put(8'h62, 16'h01FF); put(8'h64, 16'h6123);
    put(8'h66, 16'hD1AB); put(8'h68, 16'hE1CD); put(8'h6A, 16'hF1EF);
    put(8'h6C, 16'h3170); put(8'h6E, 16'hC000);
    run(8'h60, c, h);
    chk("R11 register unchanged", mem[8'h70], 8'h44);
    chk("R11 cycle count", c, 32);
  endtask

  task automatic t_same_reg();
    int c; logic h;
    do_reset(); clear_mem();
    put(8'h80, 16'h2141); put(8'h82, 16'h5111); put(8'h84, 16'h220F);
    put(8'h86, 16'h9222); put(8'h88, 16'h2381); put(8'h8A, 16'hA333);
    put(8'h8C, 16'h31F0); put(8'h8E, 16'h32F1); put(8'h90, 16'h33F2);
    put(8'h92, 16'hC000);
    run(8'h80, c, h);
    chk("R12 self add", mem[8'hF0], 8'h82);
    chk("R12 self xor", mem[8'hF1], 8'h00);
    chk("R12 self rotate", mem[8'hF2], 8'h30);
  endtask

  task automatic t_halt();
    logic [7:0] a0 = mem_addr;
    int we_seen = 0;
    int moved = 0;
    int low = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_we) we_seen++;
      if (mem_addr !== a0) moved++;
      if (!halted) low++;
    end
    chk("R10 halted stays", low, 0);
    chk("R10 no writes", we_seen, 0);
    chk("R10 address steady", moved, 0);
  endtask

  task automatic t_restart();
    int c; logic h;
    put(8'hB0, 16'h31F8); put(8'hB2, 16'hC000);
    run(8'hB0, c, h);
    chk("R13 halted cleared on go", h, 1'b0);
    chk("R13 register kept, start used", mem[8'hF8], 8'h82);
    chk("R13 cycle count", c, 8);
  endtask

  initial begin
    #750000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_load_store();
    t_alu();
    t_rotate();
    t_jump();
    t_nop();
    t_same_reg();
    t_halt();
    t_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule